// File: doc/BRIEF.md
# Receive Path Enable Controller

This block decides when the receive side of a network controller may take in frames. Software writes a single receive-enable bit. The receive engine reports three frame events as one-cycle pulses: the start of a frame, the end of its data, and the moment the frame's status word has been stored. From these inputs the block keeps a two-state machine, OFF and ON, and shows that state on a status bit that software can read.

Software can switch reception off in the middle of a frame. The frame already in flight is not cut short: the machine stays ON until the frame's data has ended and its status has been stored, and only then drops to OFF. A frame start is accepted only while the machine is ON, enable is set, and no frame is open. The engine must discard any frame start the block does not accept.

A soft reset forces the block to OFF at once and closes any open frame. After a soft reset the path stays off until software drives the enable bit low and then sets it again, even if the bit was left set through the reset.

Top module: `rx_en_ctrl`

## Requirements
- R1: After the asynchronous reset is released, `status_o`, `busy_o` and `accept_o` are 0.
- R2: With the block OFF and not locked by a soft reset, sampling `rx_en_i`=1 on a clock edge makes `status_o` 1 after that edge.
- R3: While ON, with `rx_en_i`=1 and no frame open, a `sof_i` pulse drives `accept_o` to 1 in the same cycle, and `busy_o` is 1 after the next edge.
- R4: A `sof_i` pulse while OFF, or while `rx_en_i`=0, gives `accept_o`=0 and leaves `busy_o` at 0.
- R5: While ON with no frame open, sampling `rx_en_i`=0 on an edge makes `status_o` 0 after that edge.
- R6: If `rx_en_i` is cleared while a frame is open, `status_o` stays 1. `busy_o` falls after the edge that samples `sts_done_i` following that frame's `eof_i`, and `status_o` falls one edge later.
- R7: A `sts_done_i` pulse that comes before the open frame's `eof_i` is ignored, and `busy_o` stays 1.
- R8: A `soft_rst_i` pulse makes `status_o` and `busy_o` 0 after the next edge. The block then stays OFF until `rx_en_i` has been sampled at 0 and later at 1.
- R9: A `sof_i` pulse while a frame is already open gives `accept_o`=0.
- R10: `busy_o` is never 1 while `status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset pulse |
| rx_en_i | input | 1 | Receive-enable bit from software |
| sof_i | input | 1 | Frame start pulse from the receive engine |
| eof_i | input | 1 | End of frame data pulse |
| sts_done_i | input | 1 | Frame status stored pulse |
| accept_o | output | 1 | Current frame start is accepted (combinational) |
| busy_o | output | 1 | A frame is open |
| status_o | output | 1 | Readable state bit: 1 = ON, 0 = OFF |

## Verification
The assertions assume nothing about the order of the engine's pulses. A `sts_done_i` before `eof_i`, an `eof_i` with no open frame, or a repeated `sof_i` must all be absorbed without breaking the link between `busy_o` and `status_o`. The only thing they rely on is that the inputs are synchronous to `clk_i`. The random stimulus therefore fires each event pulse on its own, independently of the others and of the frame phase, so that these out-of-order cases come up often. The enable bit changes only rarely, so that long frames regularly straddle a disable, and occasional soft resets land while the enable bit is still held high.

// File: rtl/rx_en_pkg.sv
`timescale 1ns/1ps
package rx_en_pkg;
  typedef enum logic {
    ST_OFF = 1'b0,
    ST_ON  = 1'b1
  } rx_state_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RECV  = 2'd1,
    PH_STORE = 2'd2
  } rx_phase_e;
endpackage

// File: rtl/rx_en_frame_trk.sv
`timescale 1ns/1ps
module rx_en_frame_trk
  import rx_en_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      soft_rst_i,
  input  logic      accept_i,
  input  logic      eof_i,
  input  logic      sts_done_i,
  output rx_phase_e phase_o,
  output logic      busy_o
);
  rx_phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (soft_rst_i) begin
      phase_d = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_IDLE:  if (accept_i)   phase_d = PH_RECV;
        PH_RECV:  if (eof_i)      phase_d = PH_STORE;
        PH_STORE: if (sts_done_i) phase_d = PH_IDLE;
        default:                  phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
  assign busy_o  = (phase_q != PH_IDLE);

  AST_EARLY_STS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RECV && !eof_i && !soft_rst_i) |=> busy_o); // R7
  AST_STORE_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STORE && sts_done_i && !soft_rst_i) |=> !busy_o); // R6
endmodule

// File: rtl/rx_en_rearm.sv
`timescale 1ns/1ps
module rx_en_rearm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic rx_en_i,
  output logic lock_o
);
  logic lock_q;

  // set by soft reset, released only once enable is seen low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lock_q <= 1'b0;
    else if (soft_rst_i) lock_q <= 1'b1;
    else if (!rx_en_i)   lock_q <= 1'b0;
  end

  assign lock_o = lock_q;

  AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_q && rx_en_i && !soft_rst_i) |=> lock_o); // R8
endmodule

// File: rtl/rx_en_state_fsm.sv
`timescale 1ns/1ps
module rx_en_state_fsm
  import rx_en_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      soft_rst_i,
  input  logic      rx_en_i,
  input  logic      lock_i,
  input  logic      busy_i,
  input  logic      sof_i,
  output rx_state_e state_o,
  output logic      accept_o
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (soft_rst_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF: if (rx_en_i && !lock_i)  state_d = ST_ON;
        ST_ON:  if (!rx_en_i && !busy_i) state_d = ST_OFF;
        default:                         state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign accept_o = sof_i && (state_q == ST_ON) && rx_en_i && !busy_i && !soft_rst_i;

  AST_DRAIN_STAYS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && busy_i && !soft_rst_i) |=> (state_o == ST_ON)); // R6
  AST_IDLE_DISABLE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ON && !rx_en_i && !busy_i && !soft_rst_i) |=> (state_o == ST_OFF)); // R5
  AST_LOCKED_STAYS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && lock_i) |=> (state_o == ST_OFF)); // R8
endmodule

// File: rtl/rx_en_ctrl.sv
`timescale 1ns/1ps
module rx_en_ctrl
  import rx_en_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic rx_en_i,
  input  logic sof_i,
  input  logic eof_i,
  input  logic sts_done_i,
  output logic accept_o,
  output logic busy_o,
  output logic status_o
);
  rx_state_e state;
  rx_phase_e phase;
  logic      lock;
  logic      busy;
  logic      accept;

  rx_en_rearm u_rearm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .rx_en_i    (rx_en_i),
    .lock_o     (lock)
  );

  rx_en_state_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .rx_en_i    (rx_en_i),
    .lock_i     (lock),
    .busy_i     (busy),
    .sof_i      (sof_i),
    .state_o    (state),
    .accept_o   (accept)
  );

  rx_en_frame_trk u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .accept_i   (accept),
    .eof_i      (eof_i),
    .sts_done_i (sts_done_i),
    .phase_o    (phase),
    .busy_o     (busy)
  );

  assign accept_o = accept;
  assign busy_o   = busy;
  assign status_o = (state == ST_ON);

  AST_BUSY_NEEDS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> status_o); // R10
  AST_NO_ACCEPT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o || !rx_en_i) |-> !accept_o); // R4
  AST_NO_ACCEPT_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase != PH_IDLE) |-> !accept_o); // R9
  AST_SOFT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!status_o && !busy_o)); // R8
  AST_ACCEPT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> busy_o); // R3
endmodule

// File: tb/rx_en_ctrl_tb.sv
`timescale 1ns/1ps
module rx_en_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, rx_en = 1'b0, sof = 1'b0, eof = 1'b0, sts = 1'b0;
  logic accept, busy, status;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state, derived from the requirements
  bit m_on = 1'b0;
  int m_ph = 0;    // 0 idle, 1 receiving, 2 awaiting status
  bit m_lock = 1'b0;

  always #5 clk = ~clk;

  rx_en_ctrl u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .soft_rst_i (soft_rst),
    .rx_en_i    (rx_en),
    .sof_i      (sof),
    .eof_i      (eof),
    .sts_done_i (sts),
    .accept_o   (accept),
    .busy_o     (busy),
    .status_o   (status)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_accept(bit s, bit en);
    return s && m_on && en && (m_ph == 0);
  endfunction

  task automatic step(input logic en, input logic s, input logic e,
                      input logic d, input logic sr);
    bit acc;
    bit n_on;
    bit n_lock;
    int n_ph;
    @(negedge clk);
    rx_en = en; sof = s; eof = e; sts = d; soft_rst = sr;
    #2;
    acc = sr ? 1'b0 : exp_accept(s, en);
    chk("R3|R4|R9", accept, acc);
    if (sr) begin
      n_on = 1'b0; n_ph = 0; n_lock = 1'b1;
    end else begin
      n_ph = m_ph;
      if (m_ph == 0 && acc) n_ph = 1;
      else if (m_ph == 1 && e) n_ph = 2;
      else if (m_ph == 2 && d) n_ph = 0;
      n_on = m_on ? !(!en && m_ph == 0) : (en && !m_lock);
      n_lock = m_lock && en;
    end
    @(posedge clk);
    #1;
    m_on = n_on; m_ph = n_ph; m_lock = n_lock;
    chk("R2|R5|R8", status, m_on);
    chk("R6|R7|R10", busy, m_ph != 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", status, 1'b0);
    chk("R1", busy, 1'b0);
    chk("R1", accept, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", status, 1'b0);

    // frame start while off
    step(0, 1, 0, 0, 0);
    chk("R4", busy, 1'b0);
    // enable
    step(1, 0, 0, 0, 0);
    chk("R2", status, 1'b1);
    // accepted frame
    step(1, 1, 0, 0, 0);
    chk("R3", busy, 1'b1);
    // status before eof ignored
    step(1, 0, 0, 1, 0);
    chk("R7", busy, 1'b1);
    // second start during open frame
    @(negedge clk); rx_en = 1; sof = 1; eof = 0; sts = 0; soft_rst = 0; #2;
    chk("R9", accept, 1'b0);
    step(1, 1, 0, 0, 0);
    // disable mid frame
    step(0, 0, 0, 0, 0);
    chk("R6", status, 1'b1);
    step(0, 1, 0, 0, 0);
    chk("R4", busy, 1'b1);
    step(0, 0, 1, 0, 0);
    chk("R6", status, 1'b1);
    step(0, 0, 0, 1, 0);
    chk("R6", busy, 1'b0);
    chk("R6", status, 1'b1);
    step(0, 0, 0, 0, 0);
    chk("R6", status, 1'b0);
    // idle disable
    step(1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk("R5", status, 1'b0);
    // soft reset with enable held, mid frame
    step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 1);
    chk("R8", status, 1'b0);
    chk("R8", busy, 1'b0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0);
    chk("R8", status, 1'b0);
    step(0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    chk("R8", status, 1'b1);

    // random phase
    void'($urandom(32'h5eed_0417));
    begin
      logic en_r;
      en_r = 1'b1;
      for (int i = 0; i < 4000; i++) begin
        if ($urandom_range(15) == 0) en_r = ~en_r;
        step(en_r,
             $urandom_range(5) == 0,
             $urandom_range(4) == 0,
             $urandom_range(4) == 0,
             $urandom_range(149) == 0);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule